// File: doc/BRIEF.md
# Bounded Branch and Call Unit

This block owns the program counter of a small machine whose code is an array of 16-bit words. Each cycle it can accept one decoded control command: a plain advance, an absolute or relative jump, a call, a return or a stop. Along with the command come the PC as the decoder has already advanced it past the current instruction, the condition selector, the zero and carry flags, a target or offset field, the current link register and the code length in words. From these the unit works out the next PC. It checks every PC it writes against the code length. For calls it also produces the value to write back into the link register.

Commands enter on a valid/ready handshake. `cmd_ready` depends only on the unit's own state, never on anything downstream. It stays high until a stop or a range fault, and from then on it stays low until reset. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. Its result shows on the outputs after that edge, marked by a one-cycle `res_valid`. The result stream has no back-pressure: whoever consumes the result must take it in that cycle. Flag generation, fetch and decode sit outside the block.

Top module: `brcall_unit`

## Requirements
- R1: After reset `pc_out` is 0, `halted`, `fault`, `res_valid` and `lr_we` are 0, and `cmd_ready` is 1.
- R2: An accepted command with kind 0 (advance) loads `adv_pc` into `pc_out`. Every accepted command raises `res_valid` for exactly the cycle after the accepting edge.
- R3: Jump kinds 1 and 2 take the condition code `cmd_cond`: 0 always, 1 zero flag set, 2 zero flag clear, 3 carry set, 4 carry clear, 5 to 7 never. A jump whose condition fails loads `adv_pc` and never faults, whatever its target.
- R4: A taken kind 1 (absolute jump) loads the 16-bit `tgt` into the PC.
- R5: A taken kind 2 (relative jump) with `off_from_reg`=0 adds `adv_pc` and the magnitude `tgt[7:0]`, negated when `rel_neg`=1. The magnitude is 0..127 when positive and 1..128 when negative.
- R6: With `off_from_reg`=1 the relative offset is `tgt[7:0]` read as 8-bit two's complement (-128..+127), and `tgt[15:8]` is ignored.
- R7: Kind 3 (absolute call) and kind 4 (relative call, offset as in R5/R6) load the PC like an unconditional jump. In the same cycle as `res_valid` they pulse `lr_we` for one cycle with `lr_wdata` = `adv_pc`.
- R8: Kind 5 (return) loads `lr_in` into the PC.
- R9: A PC-writing command (taken jump, call, return) whose new PC is below 0 or at or above `code_len` sets `fault`. In that case the PC keeps its previous value and there is no link write. A new PC of `code_len`-1 is legal.
- R10: Kind 6 (stop) sets `halted` and loads `adv_pc`, with no range check.
- R11: `halted` and `fault` are cleared only by reset. While either is set, `cmd_ready` is 0, commands are ignored and `pc_out` does not change.
- R12: Commands may be accepted on consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_kind | input | 3 | Command kind (R2, R4, R5, R7, R8, R10) |
| cmd_cond | input | 3 | Condition code for jumps (R3) |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| adv_pc | input | 16 | PC already advanced past the instruction |
| tgt | input | 16 | Absolute target or offset field |
| rel_neg | input | 1 | Immediate relative offset is negative |
| off_from_reg | input | 1 | Relative offset comes from a register (8-bit two's complement) |
| lr_in | input | 16 | Current link register |
| code_len | input | 16 | Code length in words |
| res_valid | output | 1 | Result of an accepted command is on the outputs |
| pc_out | output | 16 | Program counter |
| lr_we | output | 1 | Link register write enable |
| lr_wdata | output | 16 | Link register write value |
| halted | output | 1 | Normal stop reached (sticky) |
| fault | output | 1 | PC range fault (sticky) |

## Verification
The state that matters is the PC, the two sticky flags and the offset arithmetic. A wrong offset sign or extension shows as a wrong `pc_out` in the cycle right after the command is accepted. A wrong range check shows there too: either `fault` rises or it does not, and `pc_out` either freezes or moves. A sticky flag that clears on its own shows as `cmd_ready` rising again, or as `pc_out` moving while stopped, within a cycle. Boundary targets (`code_len`-1, `code_len`, -1, offsets of +127 and -128) and failed conditions that point out of range are where such errors surface.

// File: rtl/brcall_pkg.sv
package brcall_pkg;
  typedef enum logic [2:0] {
    K_STEP  = 3'd0,
    K_JABS  = 3'd1,
    K_JREL  = 3'd2,
    K_CABS  = 3'd3,
    K_CREL  = 3'd4,
    K_RET   = 3'd5,
    K_STOP  = 3'd6
  } kind_e;

  typedef enum logic [2:0] {
    C_ALWAYS = 3'd0,
    C_ZSET   = 3'd1,
    C_ZCLR   = 3'd2,
    C_CSET   = 3'd3,
    C_CCLR   = 3'd4
  } cond_e;
endpackage

// File: rtl/brcall_cond.sv
module brcall_cond
  import brcall_pkg::*;
(
  input  logic [2:0] cond,
  input  logic       z,
  input  logic       c,
  output logic       taken
);
  always_comb begin
    case (cond_e'(cond))
      C_ALWAYS: taken = 1'b1;
      C_ZSET:   taken = z;
      C_ZCLR:   taken = ~z;
      C_CSET:   taken = c;
      C_CCLR:   taken = ~c;
      default:  taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/brcall_target.sv
module brcall_target
  import brcall_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8,
  parameter int INT_W = PC_W + 2
) (
  input  logic [2:0]              kind,
  input  logic                    taken,
  input  logic [PC_W-1:0]         adv,
  input  logic [PC_W-1:0]         tgt,
  input  logic                    neg,
  input  logic                    from_reg,
  input  logic [PC_W-1:0]         lr,
  output logic signed [INT_W-1:0] cand,
  output logic                    check,
  output logic                    is_call,
  output logic                    is_stop
);
  localparam int ZX  = INT_W - PC_W;
  localparam int OEX = INT_W - OFF_W;

  logic signed [INT_W-1:0] adv_s, tgt_s, lr_s, mag_s, off_s, rel_s;

  assign adv_s = $signed({{ZX{1'b0}}, adv});
  assign tgt_s = $signed({{ZX{1'b0}}, tgt});
  assign lr_s  = $signed({{ZX{1'b0}}, lr});
  assign mag_s = $signed({{OEX{1'b0}}, tgt[OFF_W-1:0]});

  always_comb begin
    if (from_reg) off_s = $signed({{OEX{tgt[OFF_W-1]}}, tgt[OFF_W-1:0]});
    else if (neg) off_s = -mag_s;
    else          off_s = mag_s;
  end

  assign rel_s = adv_s + off_s;

  always_comb begin
    cand    = adv_s;
    check   = 1'b0;
    is_call = 1'b0;
    is_stop = 1'b0;
    case (kind_e'(kind))
      K_JABS: if (taken) begin cand = tgt_s; check = 1'b1; end
      K_JREL: if (taken) begin cand = rel_s; check = 1'b1; end
      K_CABS: begin cand = tgt_s; check = 1'b1; is_call = 1'b1; end
      K_CREL: begin cand = rel_s; check = 1'b1; is_call = 1'b1; end
      K_RET:  begin cand = lr_s;  check = 1'b1; end
      K_STOP: is_stop = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/brcall_limit.sv
module brcall_limit #(
  parameter int PC_W  = 16,
  parameter int INT_W = PC_W + 2
) (
  input  logic signed [INT_W-1:0] cand,
  input  logic [PC_W-1:0]         len,
  output logic                    in_range
);
  localparam int ZX = INT_W - PC_W;
  logic signed [INT_W-1:0] len_s;
  assign len_s    = $signed({{ZX{1'b0}}, len});
  assign in_range = (cand >= 0) && (cand < len_s);
endmodule

// File: rtl/brcall_unit.sv
module brcall_unit
  import brcall_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_kind,
  input  logic [2:0]      cmd_cond,
  input  logic            flag_z,
  input  logic            flag_c,
  input  logic [PC_W-1:0] adv_pc,
  input  logic [PC_W-1:0] tgt,
  input  logic            rel_neg,
  input  logic            off_from_reg,
  input  logic [PC_W-1:0] lr_in,
  input  logic [PC_W-1:0] code_len,
  output logic            res_valid,
  output logic [PC_W-1:0] pc_out,
  output logic            lr_we,
  output logic [PC_W-1:0] lr_wdata,
  output logic            halted,
  output logic            fault
);
  localparam int INT_W = PC_W + 2;

  logic                    taken, check, is_call, is_stop, in_range, accept;
  logic signed [INT_W-1:0] cand;

  brcall_cond u_cond (
    .cond(cmd_cond), .z(flag_z), .c(flag_c), .taken(taken)
  );

  brcall_target #(.PC_W(PC_W), .OFF_W(OFF_W), .INT_W(INT_W)) u_target (
    .kind(cmd_kind), .taken(taken), .adv(adv_pc), .tgt(tgt),
    .neg(rel_neg), .from_reg(off_from_reg), .lr(lr_in),
    .cand(cand), .check(check), .is_call(is_call), .is_stop(is_stop)
  );

  brcall_limit #(.PC_W(PC_W), .INT_W(INT_W)) u_limit (
    .cand(cand), .len(code_len), .in_range(in_range)
  );

  assign cmd_ready = ~(halted | fault);
  assign accept    = cmd_valid & cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_out    <= '0;
      lr_we     <= 1'b0;
      lr_wdata  <= '0;
      halted    <= 1'b0;
      fault     <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= accept;
      lr_we     <= 1'b0;
      if (accept) begin
        if (is_stop) begin
          halted <= 1'b1;
          pc_out <= adv_pc;
        end else if (check && !in_range) begin
          fault <= 1'b1;
        end else begin
          pc_out <= cand[PC_W-1:0];
          if (is_call) begin
            lr_we    <= 1'b1;
            lr_wdata <= adv_pc;
          end
        end
      end
    end
  end

  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R11
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  // R11
  pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted || fault) |=> $stable(pc_out));
  // R11
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted || fault) |-> !cmd_ready);
  // R2
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> res_valid);
  // R7
  link_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> res_valid);
  // R9
  no_link_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (!lr_we && $stable(pc_out)));
  // R10
  single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(halted && fault));
endmodule

// File: tb/brcall_unit_bench.sv
module brcall_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_kind = '0, cmd_cond = '0;
  logic        flag_z = 1'b0, flag_c = 1'b0;
  logic [15:0] adv_pc = '0, tgt = '0, lr_in = '0, code_len = 16'd300;
  logic        rel_neg = 1'b0, off_from_reg = 1'b0;
  logic        res_valid, lr_we, halted, fault;
  logic [15:0] pc_out, lr_wdata;

  int total = 0;
  int bad = 0;

  typedef struct {
    string       tag;
    logic [15:0] pc;
    logic        we;
    logic [15:0] lr;
    logic        h;
    logic        f;
  } exp_t;
  exp_t exp_q[$];

  int m_pc;
  bit m_halt, m_fault;

  always #4 clk = ~clk;

  brcall_unit u_brcall_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_cond(cmd_cond), .flag_z(flag_z), .flag_c(flag_c),
    .adv_pc(adv_pc), .tgt(tgt), .rel_neg(rel_neg), .off_from_reg(off_from_reg),
    .lr_in(lr_in), .code_len(code_len), .res_valid(res_valid), .pc_out(pc_out),
    .lr_we(lr_we), .lr_wdata(lr_wdata), .halted(halted), .fault(fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic send(input string tag, input logic [2:0] k, input logic [2:0] cnd,
                      input logic z, input logic c, input logic [15:0] adv,
                      input logic [15:0] t, input logic neg, input logic oreg,
                      input logic [15:0] lr, input logic [15:0] len);
    int off, cand;
    bit tk, chkr, call, flt;
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_cond = cnd; flag_z = z; flag_c = c;
    adv_pc = adv; tgt = t; rel_neg = neg; off_from_reg = oreg; lr_in = lr; code_len = len;
    if (cmd_ready) begin
      case (cnd)
        3'd0: tk = 1'b1;
        3'd1: tk = z;
        3'd2: tk = !z;
        3'd3: tk = c;
        3'd4: tk = !c;
        default: tk = 1'b0;
      endcase
      if (oreg) off = int'($signed(t[7:0]));
      else off = neg ? -int'(t[7:0]) : int'(t[7:0]);
      cand = int'(adv); chkr = 1'b0; call = 1'b0;
      case (k)
        3'd1: if (tk) begin cand = int'(t); chkr = 1'b1; end
        3'd2: if (tk) begin cand = int'(adv) + off; chkr = 1'b1; end
        3'd3: begin cand = int'(t); chkr = 1'b1; call = 1'b1; end
        3'd4: begin cand = int'(adv) + off; chkr = 1'b1; call = 1'b1; end
        3'd5: begin cand = int'(lr); chkr = 1'b1; end
        default: ;
      endcase
      flt = chkr && (cand < 0 || cand >= int'(len));
      if (k == 3'd6) begin m_halt = 1'b1; m_pc = int'(adv); end
      else if (flt) m_fault = 1'b1;
      else m_pc = cand;
      e.tag = tag; e.pc = m_pc[15:0]; e.we = call && !flt; e.lr = adv;
      e.h = m_halt; e.f = m_fault;
      exp_q.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops one expected item per result
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected result actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " pc"}, 32'(pc_out), 32'(e.pc));
        chk({e.tag, " lr_we"}, 32'(lr_we), 32'(e.we));
        if (e.we) chk({e.tag, " lr_wdata"}, 32'(lr_wdata), 32'(e.lr));
        chk({e.tag, " halted"}, 32'(halted), 32'(e.h));
        chk({e.tag, " fault"}, 32'(fault), 32'(e.f));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0;
    m_pc = 0; m_halt = 1'b0; m_fault = 1'b0;
    exp_q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc", 32'(pc_out), 32'd0);
    chk("R1 halted", 32'(halted), 32'd0);
    chk("R1 fault", 32'(fault), 32'd0);
    chk("R1 res_valid", 32'(res_valid), 32'd0);
    chk("R1 lr_we", 32'(lr_we), 32'd0);
    chk("R1 ready", 32'(cmd_ready), 32'd1);
  endtask

  task automatic check_ignored(input string tag, input logic [15:0] held);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = 3'd1; cmd_cond = 3'd0; tgt = 16'd5; code_len = 16'd300;
    repeat (3) begin
      @(negedge clk);
      chk({tag, " ready"}, 32'(cmd_ready), 32'd0);
      chk({tag, " no result"}, 32'(res_valid), 32'd0);
      chk({tag, " pc held"}, 32'(pc_out), 32'(held));
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R12: all of these go back to back, one per cycle
    send("R2 step",          3'd0, 3'd0, 0, 0, 16'd5,   16'd0,     0, 0, 16'd0, 16'd300);
    send("R4 jabs",          3'd1, 3'd0, 0, 0, 16'd6,   16'd40,    0, 0, 16'd0, 16'd300);
    send("R3 zset taken",    3'd1, 3'd1, 1, 0, 16'd41,  16'd10,    0, 0, 16'd0, 16'd300);
    send("R3 zset not",      3'd1, 3'd1, 0, 0, 16'd11,  16'd90,    0, 0, 16'd0, 16'd300);
    send("R3 zclr taken",    3'd1, 3'd2, 0, 0, 16'd12,  16'd91,    0, 0, 16'd0, 16'd300);
    send("R3 cset taken",    3'd2, 3'd3, 0, 1, 16'd92,  16'd3,     1, 0, 16'd0, 16'd300);
    send("R3 cclr not oor",  3'd1, 3'd4, 0, 1, 16'd90,  16'd9999,  0, 0, 16'd0, 16'd300);
    send("R3 never",         3'd2, 3'd6, 1, 1, 16'd91,  16'd7,     0, 0, 16'd0, 16'd300);
    send("R5 rel +127",      3'd2, 3'd0, 0, 0, 16'd20,  16'd127,   0, 0, 16'd0, 16'd300);
    send("R5 rel -128",      3'd2, 3'd4, 0, 0, 16'd200, 16'd128,   1, 0, 16'd0, 16'd300);
    send("R6 reg -128",      3'd2, 3'd0, 0, 0, 16'd150, 16'hFF80,  0, 1, 16'd0, 16'd300);
    send("R6 reg hi ignored",3'd2, 3'd0, 0, 0, 16'd10,  16'h127F,  0, 1, 16'd0, 16'd300);
    send("R7 call abs",      3'd3, 3'd0, 0, 0, 16'd30,  16'd250,   0, 0, 16'd0, 16'd300);
    send("R7 call rel",      3'd4, 3'd0, 0, 0, 16'd60,  16'd8,     1, 0, 16'd0, 16'd300);
    send("R8 ret",           3'd5, 3'd0, 0, 0, 16'd53,  16'd0,     0, 0, 16'd77, 16'd300);
    send("R9 edge len-1",    3'd1, 3'd0, 0, 0, 16'd78,  16'd299,   0, 0, 16'd0, 16'd300);
    send("R9 call to -1",    3'd4, 3'd0, 0, 0, 16'd2,   16'd3,     1, 0, 16'd0, 16'd300);
    idle(2);
    chk("R2 queue drained", 32'(exp_q.size()), 32'd0);
    check_ignored("R11 after fault", 16'd299);

    do_reset();
    send("R8 ret to len",    3'd5, 3'd0, 0, 0, 16'd4,   16'd0,     0, 0, 16'd300, 16'd300);
    idle(2);
    check_ignored("R11 after ret fault", 16'd0);

    do_reset();
    send("R9 jabs at len",   3'd1, 3'd0, 0, 0, 16'd4,   16'd20,    0, 0, 16'd0, 16'd20);
    idle(2);

    do_reset();
    send("R2 step",          3'd0, 3'd0, 0, 0, 16'd11,  16'd0,     0, 0, 16'd0, 16'd300);
    send("R10 stop",         3'd6, 3'd0, 0, 0, 16'd12,  16'd0,     0, 0, 16'd0, 16'd300);
    idle(2);
    check_ignored("R11 after stop", 16'd12);
    idle(1);
    chk("R2 queue drained end", 32'(exp_q.size()), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule